// File: doc/BRIEF.md
# Indexed Block Configuration Target on a Two-Wire Bus

This block is a target on an SMBus-style two-wire bus. It holds a small bank of 8-bit configuration and status bytes for a clock fan-out device. A host reaches these bytes through indexed block transfers. Each transfer names a starting index, and the index moves up by one after every data byte.

A block write carries three things in turn: the index, a byte count and the data bytes. A block read has two parts. First comes a write-direction header that sets the index. Then a repeated START follows with the read address. The target answers with the byte count held in its count register, followed by that many data bytes.

The bus lines are sampled by a faster system clock, deglitched, and decoded into START, STOP and bit events. SDA is only ever pulled low, through an output-enable signal. The bank drives the per-output enables, the loop-bandwidth and PLL-use controls and a 3-bit frequency select. Several bytes read back live pin levels instead of stored values.

Top module: `cfgbus_regslave`

## Requirements
- R1: The 7-bit target address is 0x68 plus `addr_strap`, so the write address byte is 0xD0 + 2·strap and the read address byte is that value plus 1. Any other address byte is not acknowledged.
- R2: A block write (address+W, index N, count X, data) acknowledges the index, the count and the first X data bytes, and stores those bytes at indices N, N+1 and onward.
- R3: In a block write, data bytes after the first X are NACKed and not stored.
- R4: A block read (address+W, index N, repeated START, address+R) first returns the value of index 7 (the count, reset value 0x07). It then returns that many bytes starting at N. If the host keeps acknowledging past them, SDA is left released, so the host reads 0xFF.
- R5: Writable bytes and their reset values are as follows. Index 1 holds enables 7..0 (0xFF). Index 2 holds bit 7 low-bandwidth, bit 6 PLL-use and bits 5:0 enables 13..8 (0xFF). Index 8 bits 4:0 hold enables 18..14 (all 1). Index 9 bits 2:0 drive `fsel` and reset to {`fsel_pin` as sampled after reset, 0, 1}.
- R6: Read-only bytes are as follows. Index 3 = {`pin_en_n`[5:0], `bw_pin`, `addr_strap`[2]}. Index 4 = {`pin_en_n`[12], `pin_en_n`[11], 0, `pin_en_n`[10:6]}. Index 5 = 0x11. Index 6 = 0xC2. Index 8 bit 7 = live `fsel_pin`, and bits 6:5 = 0. Index 0 and indices above 9 read 0x00. Writes to any of these bits are acknowledged but change nothing.
- R7: `out_en`[i] is high only when its register enable bit is 1 and its active-low pin group is 0. The pin groups are: group 0 for outputs 0..4, group i−4 for outputs 5..14, group 11 for outputs 15..16, and group 12 for outputs 17..18.
- R8: `bw_low` = index 2 bit 7 AND `bw_pin`. `pll_on` = index 2 bit 6 AND `addr_strap`[2].
- R9: `sda_oe` changes only while the deglitched SCL is low.
- R10: A START or STOP in the middle of a transfer abandons it. Bytes already stored stay, and a new transfer that follows works normally.
- R11: While `refclk_ok` is low, the target ignores the bus and keeps SDA released.
- R12: A pulse on SCL or SDA shorter than 3 system clocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| refclk_ok | input | 1 | High while the reference clock runs; the bus target works only then |
| addr_strap | input | 3 | Address select; bit 2 also gates PLL use |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | Pull SDA low when high |
| pin_en_n | input | 13 | Active-low output-enable pin groups |
| bw_pin | input | 1 | Bandwidth pin level (1 = low bandwidth) |
| fsel_pin | input | 1 | Frequency-select pin level |
| out_en | output | 19 | Per-output run enables |
| bw_low | output | 1 | Low loop bandwidth selected |
| pll_on | output | 1 | PLL in use (0 = fan-out bypass) |
| fsel | output | 3 | Frequency-select controls |

## Verification
Two functions can meet in one system-clock cycle. The bus engine may be storing a data byte at the falling SCL edge of its eighth bit while a START or STOP arrives. The bench provokes this in two ways: it breaks off a block write with a START part-way through a byte, and it sends the final byte of a counted write right before the STOP. It then reads the bank back. The bytes finished before the abort must hold their new values, and the broken byte must leave no trace. A checker also confirms that register contents move only on a write strobe and that SDA is released in the cycle after any START.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  localparam int unsigned NUM_OUT     = 19;
  localparam int unsigned NUM_PIN_GRP = 13;
  localparam logic [6:0]  BASE_ADDR   = 7'h68;

  localparam logic [7:0] IX_EN_LO  = 8'd1;
  localparam logic [7:0] IX_EN_MID = 8'd2;
  localparam logic [7:0] IX_PIN_A  = 8'd3;
  localparam logic [7:0] IX_PIN_B  = 8'd4;
  localparam logic [7:0] IX_IDS    = 8'd5;
  localparam logic [7:0] IX_DEVID  = 8'd6;
  localparam logic [7:0] IX_COUNT  = 8'd7;
  localparam logic [7:0] IX_EN_HI  = 8'd8;
  localparam logic [7:0] IX_FREQ   = 8'd9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } eng_state_t;

  // which active-low pin group gates a given output
  function automatic int unsigned pin_group(int unsigned o);
    if (o < 5)       return 0;
    else if (o < 15) return o - 4;
    else if (o < 17) return 11;
    else             return 12;
  endfunction
endpackage

// File: rtl/cfgbus_deglitch.sv
module cfgbus_deglitch #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(STAGES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q, run_d;
  logic          out_d;

  always_comb begin
    run_d = '0;
    out_d = dout;
    if (sync_q[1] != dout) begin
      if (run_q == CW'(STAGES - 1)) out_d = sync_q[1];
      else                           run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      run_q  <= run_d;
      dout   <= out_d;
    end
  end
endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_ok,
  input  logic       scl,
  input  logic       sda,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  input  logic [7:0] count_reg,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       start_ev,
  output logic       sda_oe
);
  eng_state_t state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, idx_q, idx_d, left_q, left_d;
  logic [1:0] phase_q, phase_d;
  logic       rw_q, rw_d, ack_q, ack_d, oe_d;
  logic       scl_p, sda_p, rise, fall, stop_ev;

  assign rise     = scl & ~scl_p;
  assign fall     = ~scl & scl_p;
  assign start_ev = scl & scl_p & sda_p & ~sda;
  assign stop_ev  = scl & scl_p & ~sda_p & sda;
  assign rd_idx   = idx_q;
  assign wr_idx   = idx_q;
  assign wr_data  = sh_q;

  always_comb begin
    state_d = state_q; bit_d = bit_q; sh_d = sh_q; idx_d = idx_q;
    left_d = left_q; phase_d = phase_q; rw_d = rw_q; ack_d = ack_q;
    oe_d = sda_oe; wr_en = 1'b0;
    if (!ref_ok) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR; bit_d = '0; oe_d = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (rise) begin
            sh_d = {sh_q[6:0], sda};
            bit_d = bit_q + 4'd1;
          end else if (fall && bit_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == dev_addr) begin
                oe_d = 1'b1; rw_d = sh_q[0]; state_d = ST_AACK;
              end else state_d = ST_IDLE;
            end else begin
              oe_d = 1'b1; state_d = ST_RACK;
              unique case (phase_q)
                2'd0:    begin idx_d = sh_q; phase_d = 2'd1; end
                2'd1:    begin left_d = sh_q; phase_d = 2'd2; end
                default: begin
                  if (left_q != 8'd0) begin
                    wr_en = 1'b1; idx_d = idx_q + 8'd1; left_d = left_q - 8'd1;
                  end else begin
                    oe_d = 1'b0; state_d = ST_IDLE;
                  end
                end
              endcase
            end
          end
        end
        ST_AACK: if (fall) begin
          bit_d = '0;
          if (rw_q) begin
            sh_d = count_reg; left_d = count_reg;
            oe_d = ~count_reg[7]; state_d = ST_TX;
          end else begin
            oe_d = 1'b0; phase_d = 2'd0; state_d = ST_RX;
          end
        end
        ST_RACK: if (fall) begin
          oe_d = 1'b0; bit_d = '0; state_d = ST_RX;
        end
        ST_TX: if (fall) begin
          if (bit_q == 4'd7) begin
            oe_d = 1'b0; state_d = ST_TACK;
          end else begin
            sh_d = {sh_q[6:0], 1'b1}; oe_d = ~sh_q[6]; bit_d = bit_q + 4'd1;
          end
        end
        ST_TACK: begin
          if (rise) ack_d = ~sda;
          else if (fall) begin
            if (ack_q) begin
              bit_d = '0; state_d = ST_TX;
              if (left_q != 8'd0) begin
                sh_d = rd_data; oe_d = ~rd_data[7];
                idx_d = idx_q + 8'd1; left_d = left_q - 8'd1;
              end else begin
                sh_d = 8'hFF; oe_d = 1'b0;
              end
            end else begin
              oe_d = 1'b0; state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; idx_q <= '0;
      left_q <= '0; phase_q <= '0; rw_q <= 1'b0; ack_q <= 1'b0;
      sda_oe <= 1'b0; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      state_q <= state_d; bit_q <= bit_d; sh_q <= sh_d; idx_q <= idx_d;
      left_q <= left_d; phase_q <= phase_d; rw_q <= rw_d; ack_q <= ack_d;
      sda_oe <= oe_d; scl_p <= scl; sda_p <= sda;
    end
  end
endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter logic [7:0] REV_VEND_ID = 8'h11,
  parameter logic [7:0] DEVICE_ID   = 8'hC2,
  parameter logic [7:0] COUNT_INIT  = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_idx,
  input  logic [7:0]             wr_data,
  input  logic [7:0]             rd_idx,
  input  logic [NUM_PIN_GRP-1:0] pin_en_n,
  input  logic                   bw_pin,
  input  logic                   byp_pin,
  input  logic                   fsel_pin,
  output logic [7:0]             rd_data,
  output logic [7:0]             count_reg,
  output logic [NUM_OUT-1:0]     en_bits,
  output logic                   bw_bit,
  output logic                   pll_bit,
  output logic [2:0]             fsel_bits
);
  logic [7:0] lo_q, lo_d, mid_q, mid_d, cnt_q, cnt_d;
  logic [4:0] hi_q, hi_d;
  logic [2:0] frq_q, frq_d;
  logic       ld_q, upd;

  assign upd = wr_en | ~ld_q;

  always_comb begin
    lo_d = lo_q; mid_d = mid_q; hi_d = hi_q; cnt_d = cnt_q; frq_d = frq_q;
    if (!ld_q) frq_d[2] = fsel_pin;
    if (wr_en) begin
      unique case (wr_idx)
        IX_EN_LO:  lo_d  = wr_data;
        IX_EN_MID: mid_d = wr_data;
        IX_COUNT:  cnt_d = wr_data;
        IX_EN_HI:  hi_d  = wr_data[4:0];
        IX_FREQ:   frq_d = wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 8'hFF; mid_q <= 8'hFF; hi_q <= 5'h1F;
      cnt_q <= COUNT_INIT; frq_q <= 3'b001; ld_q <= 1'b0;
    end else if (upd) begin
      lo_q <= lo_d; mid_q <= mid_d; hi_q <= hi_d;
      cnt_q <= cnt_d; frq_q <= frq_d; ld_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IX_EN_LO:  rd_data = lo_q;
      IX_EN_MID: rd_data = mid_q;
      IX_PIN_A:  rd_data = {pin_en_n[5:0], bw_pin, byp_pin};
      IX_PIN_B:  rd_data = {pin_en_n[12:11], 1'b0, pin_en_n[10:6]};
      IX_IDS:    rd_data = REV_VEND_ID;
      IX_DEVID:  rd_data = DEVICE_ID;
      IX_COUNT:  rd_data = cnt_q;
      IX_EN_HI:  rd_data = {fsel_pin, 2'b00, hi_q};
      IX_FREQ:   rd_data = {5'b0, frq_q};
      default:   rd_data = 8'h00;
    endcase
  end

  assign count_reg = cnt_q;
  assign en_bits   = {hi_q, mid_q[5:0], lo_q};
  assign bw_bit    = mid_q[7];
  assign pll_bit   = mid_q[6];
  assign fsel_bits = frq_q;
endmodule

// File: rtl/cfgbus_regslave.sv
module cfgbus_regslave
  import cfgbus_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 3,
  parameter logic [7:0]  REV_VEND_ID = 8'h11,
  parameter logic [7:0]  DEVICE_ID   = 8'hC2,
  parameter logic [7:0]  COUNT_INIT  = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   refclk_ok,
  input  logic [2:0]             addr_strap,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [NUM_PIN_GRP-1:0] pin_en_n,
  input  logic                   bw_pin,
  input  logic                   fsel_pin,
  output logic [NUM_OUT-1:0]     out_en,
  output logic                   bw_low,
  output logic                   pll_on,
  output logic [2:0]             fsel
);
  logic [1:0]         raw_lines, flt_lines;
  logic               scl_flt, sda_flt, start_pulse, wr_en, bw_bit, pll_bit;
  logic [7:0]         rd_idx, rd_data, wr_idx, wr_data, count_reg;
  logic [NUM_OUT-1:0] en_bits;
  logic [6:0]         dev_addr;

  assign raw_lines = {sda_i, scl_i};
  assign dev_addr  = BASE_ADDR + {4'b0, addr_strap};

  for (genvar l = 0; l < 2; l++) begin : g_line
    cfgbus_deglitch #(.STAGES(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .din(raw_lines[l]), .dout(flt_lines[l]));
  end
  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  cfgbus_engine u_eng (
    .clk(clk), .rst_n(rst_n), .ref_ok(refclk_ok), .scl(scl_flt), .sda(sda_flt),
    .dev_addr(dev_addr), .rd_data(rd_data), .count_reg(count_reg), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .start_ev(start_pulse),
    .sda_oe(sda_oe));

  cfgbus_regs #(.REV_VEND_ID(REV_VEND_ID), .DEVICE_ID(DEVICE_ID),
                .COUNT_INIT(COUNT_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .pin_en_n(pin_en_n), .bw_pin(bw_pin), .byp_pin(addr_strap[2]),
    .fsel_pin(fsel_pin), .rd_data(rd_data), .count_reg(count_reg), .en_bits(en_bits),
    .bw_bit(bw_bit), .pll_bit(pll_bit), .fsel_bits(fsel));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_oe
    localparam int unsigned GRP = pin_group(g);
    assign out_en[g] = en_bits[g] & ~pin_en_n[GRP];
  end

  assign bw_low = bw_bit & bw_pin;
  assign pll_on = pll_bit & addr_strap[2];
endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
  parameter int unsigned NOUT = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_f,
  input logic            sda_oe,
  input logic            ref_ok,
  input logic            start_ev,
  input logic            wr_en,
  input logic [NOUT-1:0] en_bits
);
  // R9
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);
  // R11
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> !sda_oe);
  // R10
  start_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_bits));
endmodule

bind cfgbus_regslave cfgbus_chk #(.NOUT(19)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .sda_oe(sda_oe), .ref_ok(refclk_ok),
  .start_ev(start_pulse), .wr_en(wr_en), .en_bits(en_bits));

// File: tb/sim_cfgbus_regslave.sv
module sim_cfgbus_regslave;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic refclk_ok = 1'b1, scl_h = 1'b1, sda_h = 1'b1, bw_pin = 1'b1, fsel_pin = 1'b1;
  logic [2:0] strap = 3'b100;
  logic [12:0] pin_en_n = '0;
  logic sda_oe, bw_low, pll_on;
  logic [18:0] out_en;
  logic [2:0] fsel;
  wire sda_bus = sda_h & ~sda_oe;

  cfgbus_regslave u0 (
    .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .addr_strap(strap),
    .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe), .pin_en_n(pin_en_n),
    .bw_pin(bw_pin), .fsel_pin(fsel_pin), .out_en(out_en), .bw_low(bw_low),
    .pll_on(pll_on), .fsel(fsel));

  int total = 0, bad = 0, oe_viol = 0, oe_refoff = 0;
  logic [7:0] m1 = 8'hFF, m2 = 8'hFF, m7 = 8'h07;
  logic [4:0] m8 = 5'h1F;
  logic [2:0] m9 = 3'b101;
  logic oe_prev = 1'b0;

  always @(negedge clk) begin
    if (sda_oe !== oe_prev && scl_h) oe_viol++;
    if (!refclk_ok && sda_oe) oe_refoff++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] ix);
    case (ix)
      8'd1: return m1;
      8'd2: return m2;
      8'd3: return {pin_en_n[5:0], bw_pin, strap[2]};
      8'd4: return {pin_en_n[12], pin_en_n[11], 1'b0, pin_en_n[10:6]};
      8'd5: return 8'h11;
      8'd6: return 8'hC2;
      8'd7: return m7;
      8'd8: return {fsel_pin, 2'b00, m8};
      8'd9: return {5'b0, m9};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [18:0] exp_oe();
    logic [18:0] r = {m8, m2[5:0], m1};
    for (int i = 0; i < 19; i++) begin
      int g = (i < 5) ? 0 : (i < 15) ? i - 4 : (i < 17) ? 11 : 12;
      r[i] = r[i] & ~pin_en_n[g];
    end
    return r;
  endfunction

  task automatic model_wr(input logic [7:0] ix, input logic [7:0] v);
    case (ix)
      8'd1: m1 = v;
      8'd2: m2 = v;
      8'd7: m7 = v;
      8'd8: m8 = v[4:0];
      8'd9: m9 = v[2:0];
      default: ;
    endcase
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_tx(input logic b, input bit glitch);
    sda_h = b;
    if (glitch) begin tick(3); scl_h = 1; tick(2); scl_h = 0; tick(Q - 5); end
    else tick(Q);
    scl_h = 1; tick(2 * Q); scl_h = 0; tick(Q);
  endtask

  task automatic bit_rx(output logic b);
    sda_h = 1; tick(Q); scl_h = 1; tick(Q); b = sda_bus; tick(Q); scl_h = 0; tick(Q);
  endtask

  task automatic do_start();
    sda_h = 1; tick(Q); scl_h = 1; tick(2 * Q); sda_h = 0; tick(2 * Q); scl_h = 0; tick(Q);
  endtask

  task automatic do_stop();
    sda_h = 0; tick(Q); scl_h = 1; tick(2 * Q); sda_h = 1; tick(2 * Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack, input bit glitch);
    logic b;
    for (int i = 7; i >= 0; i--) bit_tx(v[i], glitch && i == 4);
    bit_rx(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_rx(b); v[i] = b; end
    bit_tx(!ack_it, 0);
  endtask

  // block write: returns number of acknowledged bytes after the address
  task automatic wr_txn(input logic [7:0] ad, input logic [7:0] ix, input logic [7:0] cnt,
                        input logic [7:0] d [8], input int n, input bit glitch,
                        output int acks);
    logic a;
    acks = 0;
    do_start();
    put_byte(ad, a, 0);
    if (a) begin
      put_byte(ix, a, 0); acks += int'(a);
      put_byte(cnt, a, 0); acks += int'(a);
      for (int j = 0; j < n; j++) begin put_byte(d[j], a, glitch); acks += int'(a); end
    end else acks = -1;
    do_stop();
  endtask

  task automatic rd_txn(input logic [7:0] ad, input logic [7:0] ix, input int n,
                        output logic [7:0] cb, output logic [7:0] d [8]);
    logic a;
    do_start(); put_byte(ad, a, 0); put_byte(ix, a, 0);
    do_start(); put_byte(ad | 8'h01, a, 0);
    get_byte(cb, n > 0);
    for (int j = 0; j < n; j++) get_byte(d[j], j != n - 1);
    do_stop();
  endtask

  task automatic check_read(input string req, input logic [7:0] ix, input int n);
    logic [7:0] cb; logic [7:0] d [8];
    rd_txn(8'hD0 + {4'b0, strap, 1'b0}, ix, n, cb, d);
    chk({req, " count"}, cb, m7);
    for (int j = 0; j < n; j++) chk(req, d[j], exp_rd(ix + 8'(j)));
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_up();
  end

  initial begin
    logic [7:0] d [8];
    logic [7:0] cb;
    logic a;
    int acks;
    void'($urandom(32'd77));
    tick(4); rst_n = 1; tick(10);
    fsel_pin = 0;

    // R5 reset state
    chk("R5 out_en reset", out_en, 19'h7FFFF);
    chk("R5 fsel reset", fsel, 3'b101);
    chk("R8 bw/pll reset", {bw_low, pll_on}, 2'b11);
    chk("R9 sda idle", sda_oe, 0);
    // R4 R6 full read from index 0 with reset count 7
    check_read("R6 reset map", 8'd0, 7);

    // R1 address decode
    strap = 3'b011; tick(5);
    chk("R8 pll gated by strap", pll_on, 0);
    do_start(); put_byte(8'hD6, a, 0); do_stop(); chk("R1 strap 011 ack", a, 1);
    do_start(); put_byte(8'hD8, a, 0); do_stop(); chk("R1 old addr nack", a, 0);
    strap = 3'b100; tick(5);
    do_start(); put_byte(8'hD2, a, 0); do_stop(); chk("R1 wrong addr nack", a, 0);

    // R2 R3 counted write, extra byte refused
    d[0] = 8'hA5; d[1] = 8'h3C; d[2] = 8'h77;
    wr_txn(8'hD8, 8'd1, 8'd2, d, 3, 0, acks);
    chk("R3 acks (idx,cnt,2 data)", acks, 4);
    model_wr(1, 8'hA5); model_wr(2, 8'h3C);
    check_read("R2 readback", 8'd1, 3);
    chk("R3 idx3 untouched via out_en", out_en, exp_oe());

    // R7 R8 pin gating
    for (int k = 0; k < 4; k++) begin
      pin_en_n = 13'($urandom); bw_pin = 1'($urandom); tick(3);
      chk("R7 out_en gating", out_en, exp_oe());
      chk("R8 bw_low", bw_low, m2[7] & bw_pin);
    end

    // R6 read-only writes ignored; R5 freq byte and high enables
    d[0] = 8'h00; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
    wr_txn(8'hD8, 8'd3, 8'd4, d, 4, 0, acks);
    chk("R6 ro writes acked", acks, 6);
    d[0] = 8'hE0; d[1] = 8'hFE;
    wr_txn(8'hD8, 8'd8, 8'd2, d, 2, 0, acks);
    model_wr(8, 8'hE0); model_wr(9, 8'hFE);
    chk("R5 fsel written", fsel, 3'b110);
    chk("R5 high enables cleared", out_en, exp_oe());
    check_read("R6 ro readback", 8'd3, 7);

    // R4 count register controls read length; release past it
    d[0] = 8'h02;
    wr_txn(8'hD8, 8'd7, 8'd1, d, 1, 0, acks); model_wr(7, 8'h02);
    rd_txn(8'hD8, 8'd8, 3, cb, d);
    chk("R4 count byte", cb, 8'h02);
    chk("R4 byte0", d[0], exp_rd(8));
    chk("R4 byte1", d[1], exp_rd(9));
    chk("R4 past count released", d[2], 8'hFF);
    check_read("R6 beyond 9 reads zero", 8'd10, 2);

    // R10 abort by START inside a data byte
    do_start(); put_byte(8'hD8, a, 0); put_byte(8'd1, a, 0); put_byte(8'd3, a, 0);
    put_byte(8'h11, a, 0);
    bit_tx(1, 0); bit_tx(0, 0); bit_tx(1, 0);
    do_start(); do_stop();
    model_wr(1, 8'h11);
    check_read("R10 abort keeps stored byte", 8'd1, 2);
    // R10 write ending right before STOP
    d[0] = 8'hC3;
    wr_txn(8'hD8, 8'd2, 8'd1, d, 1, 0, acks); model_wr(2, 8'hC3);
    check_read("R10 last byte before stop", 8'd1, 2);

    // R12 glitch on SCL inside data bits
    d[0] = 8'h5A;
    wr_txn(8'hD8, 8'd1, 8'd1, d, 1, 1, acks); model_wr(1, 8'h5A);
    chk("R12 glitch acks", acks, 3);
    check_read("R12 glitch data", 8'd1, 2);

    // R11 reference clock stopped
    refclk_ok = 0; tick(3);
    do_start(); put_byte(8'hD8, a, 0); do_stop();
    chk("R11 no ack while ref off", a, 0);
    refclk_ok = 1; tick(3);
    check_read("R11 recovered", 8'd5, 2);

    // random mixed traffic
    for (int it = 0; it < 10; it++) begin
      logic [7:0] ix;
      int n;
      ix = 8'($urandom % 12);
      n = 1 + int'($urandom % 3);
      for (int j = 0; j < n; j++) begin
        d[j] = 8'($urandom);
        if (ix + 8'(j) == 8'd7) d[j] = 8'(1 + $urandom % 3);
      end
      wr_txn(8'hD8, ix, 8'(n), d, n, 0, acks);
      chk("R2 random acks", acks, n + 2);
      for (int j = 0; j < n; j++) model_wr(ix + 8'(j), d[j]);
      pin_en_n = 13'($urandom); tick(3);
      chk("R7 random out_en", out_en, exp_oe());
      chk("R5 random fsel", fsel, m9);
      check_read("R4 random read", 8'($urandom % 12), int'(m7));
    end

    chk("R9 sda changes only with scl low", oe_viol, 0);
    chk("R11 sda released while ref off", oe_refoff, 0);
    finish_up();
  end
endmodule